// File: doc/BRIEF.md
# Eight-Bit Indexed Bit Latch

This block keeps an eight-bit output word. A three-bit index picks one of its bits, and that bit can be loaded from a single data input. Two active-low controls decide what the block does on each rising clock edge. One is a functional clear and the other is a write enable. Together they give four modes:

- **Clear:** the whole word goes to zero.
- **Decode:** the indexed bit takes the data value and every other bit goes low.
- **Hold:** nothing changes.
- **Indexed write:** only the indexed bit is updated and the others keep their values.

The block is a clocked model of a transparent addressable latch. While the write enable is low, the word follows the inputs once per cycle. When the enable returns high, the word keeps what it last captured.

An asynchronous system reset is separate from the functional clear. It puts the word into a known all-zero state at power-up.

Top module: `indexed_bit_latch`

## Requirements
- R1: With `clr_n` low and `wen_n` high (clear mode), every bit of `q` is 0 after the next rising edge, whatever `sel` and `din` are.
- R2: With `clr_n` low and `wen_n` low (decode mode), after the next rising edge bit `sel` of `q` equals `din` and the other seven bits are 0. With `din` high this makes `q` one-hot.
- R3: With `clr_n` high and `wen_n` high (hold mode), `q` does not change across the edge, whatever `sel` and `din` are.
- R4: With `clr_n` high and `wen_n` low (indexed write mode), after the edge bit `sel` of `q` equals `din` and the other seven bits keep their previous values.
- R5: `sel` is an unsigned binary index with `sel[0]` as its least significant bit. Value 0 addresses `q[0]` and value 7 addresses `q[7]`.
- R6: Once `wen_n` returns high, `q` keeps the value captured at the last rising edge that saw `wen_n` low, even if `din` and `sel` then change.
- R7: `sel` and `din` may change every cycle while `wen_n` is low. In indexed write mode, a bit written earlier in the same window keeps its value. In decode mode, that bit is forced to 0 once the index moves away from it.
- R8: While `rst_n` is low, `q` is 0 at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all updates on its rising edge |
| rst_n | input | 1 | Asynchronous system reset, active low |
| clr_n | input | 1 | Functional clear, active low |
| wen_n | input | 1 | Write enable, active low |
| sel | input | 3 | Bit index, sel[0] least significant |
| din | input | 1 | Data bit for the indexed output |
| q | output | 8 | Stored word |

## Verification
The assertions assume that `clr_n`, `wen_n`, `sel` and `din` are settled and free of unknowns at each rising edge once `rst_n` is high. They also assume that `rst_n` is released away from a clock edge. The bench meets these assumptions by changing inputs only on the falling edge and by always driving known values. Its random stimulus covers all four control combinations, with the index and data changing every cycle, so the per-cycle index changes inside a low-enable window happen often.

// File: rtl/ibl_pkg.sv
package ibl_pkg;

  typedef enum logic [1:0] {
    IBL_DECODE = 2'b00,
    IBL_CLEAR  = 2'b01,
    IBL_WRITE  = 2'b10,
    IBL_HOLD   = 2'b11
  } ibl_mode_e;

  // Mode from the two active-low controls: {clear_n, enable_n}
  function automatic ibl_mode_e ibl_mode_of(input logic clr_n, input logic wen_n);
    return ibl_mode_e'({clr_n, wen_n});
  endfunction

  // Next value of one stored bit
  function automatic logic ibl_next_bit(input ibl_mode_e mode, input logic hit,
                                        input logic din, input logic cur);
    logic nb;
    unique case (mode)
      IBL_CLEAR:  nb = 1'b0;
      IBL_DECODE: nb = hit & din;
      IBL_HOLD:   nb = cur;
      IBL_WRITE:  nb = hit ? din : cur;
      default:    nb = cur;
    endcase
    return nb;
  endfunction

endpackage

// File: rtl/ibl_mode_dec.sv
module ibl_mode_dec
  import ibl_pkg::*;
(
  input  logic      clr_n,
  input  logic      wen_n,
  output ibl_mode_e mode,
  output logic      is_clear,
  output logic      is_decode,
  output logic      is_hold,
  output logic      is_write
);
  assign mode      = ibl_mode_of(clr_n, wen_n);
  assign is_clear  = (mode == IBL_CLEAR);
  assign is_decode = (mode == IBL_DECODE);
  assign is_hold   = (mode == IBL_HOLD);
  assign is_write  = (mode == IBL_WRITE);
endmodule

// File: rtl/ibl_sel_dec.sv
module ibl_sel_dec #(
  parameter int IDX_W = 3,
  localparam int NB   = 1 << IDX_W
) (
  input  logic [IDX_W-1:0] sel,
  output logic [NB-1:0]    hit
);
  for (genvar i = 0; i < NB; i++) begin : g_hit
    assign hit[i] = (sel == IDX_W'(i));
  end
endmodule

// File: rtl/ibl_bit_cell.sv
module ibl_bit_cell
  import ibl_pkg::*;
(
  input  ibl_mode_e mode,
  input  logic      hit,
  input  logic      din,
  input  logic      cur,
  output logic      nxt
);
  assign nxt = ibl_next_bit(mode, hit, din, cur);
endmodule

// File: rtl/indexed_bit_latch.sv
module indexed_bit_latch
  import ibl_pkg::*;
#(
  parameter int IDX_W = 3,
  localparam int NB   = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_n,
  input  logic             wen_n,
  input  logic [IDX_W-1:0] sel,
  input  logic             din,
  output logic [NB-1:0]    q
);
  ibl_mode_e       mode;
  logic            is_clear, is_decode, is_hold, is_write;
  logic [NB-1:0]   hit;
  logic [NB-1:0]   q_nxt;

  ibl_mode_dec u_mode (
    .clr_n(clr_n), .wen_n(wen_n), .mode(mode),
    .is_clear(is_clear), .is_decode(is_decode),
    .is_hold(is_hold), .is_write(is_write)
  );

  ibl_sel_dec #(.IDX_W(IDX_W)) u_sel (.sel(sel), .hit(hit));

  for (genvar i = 0; i < NB; i++) begin : g_cell
    ibl_bit_cell u_cell (
      .mode(mode), .hit(hit[i]), .din(din), .cur(q[i]), .nxt(q_nxt[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end

  // R1
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_clear |=> (q == '0));

  // R2
  decode_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_decode |=> ($countones(q) <= 1) && (q[$past(sel)] == $past(din)));

  // R3
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_hold |=> $stable(q));

  // R4
  write_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_write |=> (q[$past(sel)] == $past(din)));

  // R4
  write_others_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_write |=> ((q & ~$past(hit)) == ($past(q) & ~$past(hit))));

  // R5
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit) && hit[sel]);

  // R8
  always @(posedge clk) begin
    if (!rst_n) sysrst_zero_chk: assert (q == '0);
  end
endmodule

// File: tb/tb_indexed_bit_latch.sv
module tb_indexed_bit_latch;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clr_n = 1'b1;
  logic       wen_n = 1'b1;
  logic [2:0] sel = '0;
  logic       din = 1'b0;
  logic [7:0] q;

  logic [7:0] model = '0;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  indexed_bit_latch dut (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .wen_n(wen_n),
    .sel(sel), .din(din), .q(q)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] ref_next(logic [7:0] cur, logic c, logic w,
                                          logic [2:0] a, logic d);
    logic [7:0] m;
    m = 8'd1 << a;
    if (!c && w)  return 8'h00;
    if (!c && !w) return d ? m : 8'h00;
    if (c && w)   return cur;
    return d ? (cur | m) : (cur & ~m);
  endfunction

  function automatic string mode_tag(logic c, logic w);
    if (!c && w)  return "R1";
    if (!c && !w) return "R2";
    if (c && w)   return "R3";
    return "R4";
  endfunction

  task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: q=%b expected %b", tag, got, exp);
    end
  endtask

  task automatic cyc(logic c, logic w, logic [2:0] a, logic d, string tag);
    logic [7:0] exp;
    @(negedge clk);
    clr_n = c; wen_n = w; sel = a; din = d;
    exp = ref_next(model, c, w, a, d);
    @(posedge clk);
    #1;
    model = exp;
    check(tag, q, exp);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    checks++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    // R8: reset state
    repeat (3) @(negedge clk);
    check("R8", q, 8'h00);
    rst_n = 1'b1;

    // R5: index mapping at both ends and middle
    cyc(1, 0, 3'd0, 1, "R5");
    check("R5", q, 8'b0000_0001);
    cyc(1, 0, 3'd7, 1, "R5");
    check("R5", q, 8'b1000_0001);
    cyc(1, 0, 3'd2, 1, "R5");
    check("R5", q, 8'b1000_0101);

    // R3: hold ignores index and data
    cyc(1, 1, 3'd4, 1, "R3");
    cyc(1, 1, 3'd0, 0, "R3");

    // R1: clear
    cyc(0, 1, 3'd5, 1, "R1");

    // Exhaustive: all modes, all indices, both data values, from a random start
    for (int md = 0; md < 4; md++) begin
      for (int a = 0; a < 8; a++) begin
        for (int d = 0; d < 2; d++) begin
          // seed a random word through writes
          for (int b = 0; b < 8; b++) cyc(1, 0, 3'(b), 1'($urandom), "R4");
          cyc(md[1], md[0], 3'(a), d[0], mode_tag(md[1], md[0]));
        end
      end
    end

    // R7: index moves inside one low-enable window
    cyc(0, 1, 3'd0, 0, "R1");
    cyc(1, 0, 3'd2, 1, "R7");
    cyc(1, 0, 3'd5, 1, "R7");
    check("R7", q, 8'b0010_0100);
    cyc(0, 0, 3'd2, 1, "R7");
    cyc(0, 0, 3'd5, 1, "R7");
    check("R7", q, 8'b0010_0000);

    // R6: value kept after enable returns high
    cyc(1, 0, 3'd6, 1, "R6");
    cyc(1, 1, 3'd6, 0, "R6");
    cyc(1, 1, 3'd1, 1, "R6");
    check("R6", q, 8'b0110_0000);

    // Random mix
    for (int n = 0; n < 3000; n++) begin
      logic c, w;
      c = ($urandom % 4) != 0;
      w = 1'($urandom);
      cyc(c, w, 3'($urandom), 1'($urandom), mode_tag(c, w));
    end

    // R8: asynchronous reset mid-run, no edge needed
    cyc(1, 0, 3'd3, 1, "R4");
    cyc(1, 1, 3'd3, 1, "R3");
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R8", q, 8'h00);
    model = '0;
    @(negedge clk);
    rst_n = 1'b1;
    cyc(1, 1, 3'd0, 1, "R3");

    finish_run();
  end
endmodule